// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Collector

This block gathers 64 interrupt request lines into one processor interrupt output. Each source has a 2-bit priority, an enable and a software-force bit. From the sources that are requesting and enabled, the block picks one winner. It reports the winner's index and a vector address built from a programmable table base. The index is the source number, 0 to 63.

The block tracks which of the four priority levels are in service. Software marks the current winner as in service in one of two ways, chosen by a control bit: a write to the vector register, or a read of the vector register. At the end of its handler, software releases a level through a level-acknowledge register. With nesting enabled, only a strictly higher level can preempt a level that is in service. With nesting disabled, nothing new is presented while any level is in service.

Software reaches the block through a simple 32-bit register port. Each register has four aliases selected by address bits [3:2]: plain write, set the written ones, clear the written ones, and toggle the written ones. Raw request lines can be read directly for diagnostics. A scratch register supplies the vector returned when no source is winning.

Top module: `irq_collector`

## Requirements
- R1: After reset, the control, configuration, base and scratch registers read zero, no level is in service, and `cpu_irq` is low even with every request line high.
- R2: For the control (0x020), configuration, base (0x160) and scratch (0x1F0) registers, a write at offset +0x0 replaces the value, +0x4 ORs in the written ones, +0x8 clears the written ones, and +0xC toggles the written ones. Control keeps only bit 16 (IRQ enable), bit 18 (read-entry mode) and bit 19 (nesting off). The base register keeps bits [31:2].
- R3: Source n is configured in byte n%4 of the word at 0x060 + (n/4)*0x10. In that byte, bits [1:0] are the priority, bit 2 is the enable and bit 3 forces a request. A source is pending when (line OR force) AND enable. Bits [7:4] read zero.
- R4: The winner is the pending source of the highest priority that is eligible; among sources of equal priority, the lowest index wins.
- R5: With a winner, the status register (0x030) reads the index in bits [5:0], and the vector register (0x000) reads base + 4*index. With no winner, status reads 0 and the vector register reads the scratch value.
- R6: With read-entry mode off, a write to the vector register sets the in-service bit of the winner's level, and a read has no such effect. With the mode on, a read enters the winner's level and a write has no such effect. Neither access changes state when there is no winner.
- R7: Writing a 1 to bit l of the level-acknowledge register (0x010) clears level l's in-service bit.
- R8: With nesting on, a source is eligible only if its level is above every in-service level. With nesting off, no source is eligible while any level is in service.
- R9: `cpu_irq` is high exactly when the IRQ enable bit is set and a winner exists. It follows the request lines without a clock delay.
- R10: 0x040 reads request lines 0–31 and 0x050 reads lines 32–63, unmasked.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd`. It is zero in every other cycle and for unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 64 | Level-sensitive interrupt requests |
| bus_addr | input | 9 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The arbitration table uses a fixed configuration with sources at every priority level. It applies request patterns that separate these cases: a single source, priority beating index, a tie within one level broken by the lower index, a requesting source that is disabled, the top index against a middle one, and all lines high. Each pattern checks `cpu_irq`, the status index and the vector address together. Directed sequences then step in-service state through entry, preemption by a higher level, blocking by an equal or lower level, and acknowledge. This is done under write-entry, read-entry and nesting-off modes, so that a wrong entry trigger or a wrong eligibility rule shows up as an `cpu_irq` value that should not be there.

// File: rtl/irq_collector_pkg.sv
`timescale 1ns/1ps
package irq_collector_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 9;
  localparam int SLOT_W = ADDR_W - 4;

  // word slots: address bits [ADDR_W-1:4]
  localparam logic [SLOT_W-1:0] SLOT_VEC     = 5'd0;
  localparam logic [SLOT_W-1:0] SLOT_ACK     = 5'd1;
  localparam logic [SLOT_W-1:0] SLOT_CTRL    = 5'd2;
  localparam logic [SLOT_W-1:0] SLOT_STAT    = 5'd3;
  localparam logic [SLOT_W-1:0] SLOT_RAW_LO  = 5'd4;
  localparam logic [SLOT_W-1:0] SLOT_RAW_HI  = 5'd5;
  localparam logic [SLOT_W-1:0] SLOT_CFG0    = 5'd6;
  localparam logic [SLOT_W-1:0] SLOT_BASE    = 5'd22;
  localparam logic [SLOT_W-1:0] SLOT_SCRATCH = 5'd31;

  // control bit positions
  localparam int CTRL_IRQ_EN   = 16;
  localparam int CTRL_RD_ENTRY = 18;
  localparam int CTRL_NO_NEST  = 19;
  localparam logic [DATA_W-1:0] CTRL_MASK =
    (32'd1 << CTRL_IRQ_EN) | (32'd1 << CTRL_RD_ENTRY) | (32'd1 << CTRL_NO_NEST);

  // per-source field layout (low nibble of each byte)
  localparam int FLD_W       = 4;
  localparam int FLD_EN_BIT  = 2;
  localparam int FLD_SW_BIT  = 3;
  localparam int SRC_PER_WORD = 4;

  typedef enum logic [1:0] {
    ALIAS_PLAIN = 2'd0,
    ALIAS_SET   = 2'd1,
    ALIAS_CLR   = 2'd2,
    ALIAS_TGL   = 2'd3
  } alias_e;

  function automatic logic [DATA_W-1:0] alias_apply(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] wd,
    input alias_e            kind
  );
    case (kind)
      ALIAS_SET: alias_apply = cur | wd;
      ALIAS_CLR: alias_apply = cur & ~wd;
      ALIAS_TGL: alias_apply = cur ^ wd;
      default:   alias_apply = wd;
    endcase
  endfunction

endpackage

// File: rtl/irq_lowest_idx.sv
`timescale 1ns/1ps
module irq_lowest_idx #(
  parameter int N = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any = |vec;

endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int NSRC = 64,
  parameter int NLVL = 4,
  localparam int LVL_W = $clog2(NLVL),
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]            req,
  input  logic [NSRC-1:0][LVL_W-1:0] prio,
  input  logic [NLVL-1:0]            insvc,
  input  logic                       no_nest,
  output logic                       win_valid,
  output logic [IDX_W-1:0]           win_idx,
  output logic [LVL_W-1:0]           win_lvl
);

  logic [NLVL-1:0]             lvl_any;
  logic [NLVL-1:0]             allowed;
  logic [NLVL-1:0][IDX_W-1:0]  lvl_idx;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    logic [NSRC-1:0] lvl_mask;

    always_comb begin
      for (int s = 0; s < NSRC; s++) begin
        lvl_mask[s] = req[s] && (prio[s] == LVL_W'(l));
      end
    end

    irq_lowest_idx #(.N(NSRC)) u_pick (
      .vec (lvl_mask),
      .any (lvl_any[l]),
      .idx (lvl_idx[l])
    );

    // eligible only above all active levels, or with nothing active when nesting is off
    assign allowed[l] = no_nest ? ~|insvc : ~|insvc[NLVL-1:l];
  end

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (lvl_any[l] && allowed[l]) begin
        win_valid = 1'b1;
        win_idx   = lvl_idx[l];
        win_lvl   = LVL_W'(l);
      end
    end
  end

endmodule

// File: rtl/irq_cfg_bank.sv
`timescale 1ns/1ps
module irq_cfg_bank
  import irq_collector_pkg::*;
#(
  parameter int NSRC = 64,
  localparam int LVL_W = 2,
  localparam int NWORD = NSRC / SRC_PER_WORD,
  localparam int WIDX_W = (NWORD > 1) ? $clog2(NWORD) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  alias_e                     wr_kind,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [WIDX_W-1:0]          word_sel,
  output logic [DATA_W-1:0]          word_data,
  output logic [NSRC-1:0][LVL_W-1:0] prio_o,
  output logic [NSRC-1:0]            en_o,
  output logic [NSRC-1:0]            sw_o
);

  logic [NSRC-1:0][FLD_W-1:0] fld_q;
  logic [DATA_W-1:0]          word_next;

  // assemble the addressed word; upper nibble of each byte reads zero
  always_comb begin
    word_data = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (word_sel == WIDX_W'(s / SRC_PER_WORD)) begin
        word_data[8*(s % SRC_PER_WORD) +: FLD_W] = fld_q[s];
      end
    end
  end

  assign word_next = alias_apply(word_data, wr_data, wr_kind);

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q <= '0;
    end else if (wr_en) begin
      for (int s = 0; s < NSRC; s++) begin
        if (word_sel == WIDX_W'(s / SRC_PER_WORD)) begin
          fld_q[s] <= word_next[8*(s % SRC_PER_WORD) +: FLD_W];
        end
      end
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_out
    assign prio_o[s] = fld_q[s][LVL_W-1:0];
    assign en_o[s]   = fld_q[s][FLD_EN_BIT];
    assign sw_o[s]   = fld_q[s][FLD_SW_BIT];
  end

endmodule

// File: rtl/irq_inservice.sv
`timescale 1ns/1ps
module irq_inservice #(
  parameter int NLVL = 4,
  localparam int LVL_W = $clog2(NLVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter,
  input  logic [LVL_W-1:0] enter_lvl,
  input  logic [NLVL-1:0]  ack,
  output logic [NLVL-1:0]  insvc_o
);

  logic [NLVL-1:0] insvc_q;
  logic [NLVL-1:0] enter_mask;

  assign enter_mask = enter ? (NLVL'(1) << enter_lvl) : '0;

  always_ff @(posedge clk) begin
    if (rst) insvc_q <= '0;
    else     insvc_q <= (insvc_q & ~ack) | enter_mask;
  end

  assign insvc_o = insvc_q;

endmodule

// File: rtl/irq_collector.sv
`timescale 1ns/1ps
module irq_collector
  import irq_collector_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int NLVL = 4,
  localparam int LVL_W = $clog2(NLVL),
  localparam int IDX_W = $clog2(NSRC),
  localparam int NWORD = NSRC / SRC_PER_WORD,
  localparam int WIDX_W = (NWORD > 1) ? $clog2(NWORD) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_lines,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_irq
);

  // ---------------- address decode ----------------
  logic [SLOT_W-1:0] slot;
  alias_e            kind;
  logic [SLOT_W-1:0] cfg_off;
  logic              cfg_hit;
  logic              addr_unused;

  assign slot        = bus_addr[ADDR_W-1:4];
  assign kind        = alias_e'(bus_addr[3:2]);
  assign addr_unused = ^bus_addr[1:0];
  assign cfg_off     = slot - SLOT_CFG0;
  assign cfg_hit     = (slot >= SLOT_CFG0) && (cfg_off < SLOT_W'(NWORD));

  // ---------------- plain registers ----------------
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:2] base_q;
  logic [DATA_W-1:0] scratch_q;
  logic [DATA_W-1:0] ctrl_next, base_next, scratch_next;

  always_comb begin
    ctrl_next    = alias_apply(ctrl_q, bus_wdata, kind) & CTRL_MASK;
    base_next    = alias_apply({base_q, 2'b00}, bus_wdata, kind);
    scratch_next = alias_apply(scratch_q, bus_wdata, kind);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      base_q    <= '0;
      scratch_q <= '0;
    end else if (bus_wr) begin
      if (slot == SLOT_CTRL)    ctrl_q    <= ctrl_next;
      if (slot == SLOT_BASE)    base_q    <= base_next[DATA_W-1:2];
      if (slot == SLOT_SCRATCH) scratch_q <= scratch_next;
    end
  end

  logic irq_en, rd_entry, no_nest;
  assign irq_en   = ctrl_q[CTRL_IRQ_EN];
  assign rd_entry = ctrl_q[CTRL_RD_ENTRY];
  assign no_nest  = ctrl_q[CTRL_NO_NEST];

  // ---------------- per-source configuration ----------------
  logic [NSRC-1:0][LVL_W-1:0] src_prio;
  logic [NSRC-1:0]            src_en;
  logic [NSRC-1:0]            src_sw;
  logic [DATA_W-1:0]          cfg_word;

  irq_cfg_bank #(.NSRC(NSRC)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr && cfg_hit),
    .wr_kind   (kind),
    .wr_data   (bus_wdata),
    .word_sel  (cfg_off[WIDX_W-1:0]),
    .word_data (cfg_word),
    .prio_o    (src_prio),
    .en_o      (src_en),
    .sw_o      (src_sw)
  );

  // ---------------- arbitration ----------------
  logic [NSRC-1:0]  req_eff;
  logic [NLVL-1:0]  insvc;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl;

  assign req_eff = (irq_lines | src_sw) & src_en;

  irq_arbiter #(.NSRC(NSRC), .NLVL(NLVL)) u_arb (
    .req       (req_eff),
    .prio      (src_prio),
    .insvc     (insvc),
    .no_nest   (no_nest),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  // ---------------- in-service tracking ----------------
  logic            vec_hit, enter;
  logic [NLVL-1:0] ack;

  assign vec_hit = (slot == SLOT_VEC);
  assign enter   = win_valid && vec_hit &&
                   ((bus_wr && !rd_entry) || (bus_rd && rd_entry));
  assign ack     = (bus_wr && slot == SLOT_ACK) ? bus_wdata[NLVL-1:0] : '0;

  irq_inservice #(.NLVL(NLVL)) u_svc (
    .clk       (clk),
    .rst       (rst),
    .enter     (enter),
    .enter_lvl (win_lvl),
    .ack       (ack),
    .insvc_o   (insvc)
  );

  // ---------------- vector and status ----------------
  logic [DATA_W-1:0] vec_val;
  logic [DATA_W-1:0] stat_val;

  assign vec_val  = win_valid ? ({base_q, 2'b00} + (DATA_W'(win_idx) << 2)) : scratch_q;
  assign stat_val = win_valid ? DATA_W'(win_idx) : '0;

  // ---------------- raw view ----------------
  logic [2*DATA_W-1:0] raw_ext;
  always_comb begin
    raw_ext = '0;
    raw_ext[NSRC-1:0] = irq_lines;
  end

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rd_mux = '0;
    if (cfg_hit) begin
      rd_mux = cfg_word;
    end else begin
      case (slot)
        SLOT_VEC:     rd_mux = vec_val;
        SLOT_CTRL:    rd_mux = ctrl_q;
        SLOT_STAT:    rd_mux = stat_val;
        SLOT_RAW_LO:  rd_mux = raw_ext[DATA_W-1:0];
        SLOT_RAW_HI:  rd_mux = raw_ext[2*DATA_W-1:DATA_W];
        SLOT_BASE:    rd_mux = {base_q, 2'b00};
        SLOT_SCRATCH: rd_mux = scratch_q;
        default:      rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
    else             rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;
  assign cpu_irq   = irq_en && win_valid;

endmodule

// File: rtl/irq_collector_chk.sv
`timescale 1ns/1ps
module irq_collector_chk #(
  parameter int NSRC = 64,
  parameter int NLVL = 4,
  localparam int LVL_W = $clog2(NLVL),
  localparam int IDX_W = $clog2(NSRC)
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_irq,
  input logic             irq_en,
  input logic             no_nest,
  input logic [NLVL-1:0]  insvc,
  input logic             win_valid,
  input logic [IDX_W-1:0] win_idx,
  input logic [LVL_W-1:0] win_lvl,
  input logic [NSRC-1:0]  req_eff,
  input logic             enter,
  input logic [NLVL-1:0]  ack,
  input logic             bus_rd,
  input logic [31:0]      bus_rdata
);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> (irq_en && win_valid)); // R9

  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> req_eff[win_idx]); // R4

  AST_WINNER_ABOVE_SERVICE: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> ((insvc >> win_lvl) == '0)); // R8

  AST_NO_NEST_IDLE: assert property (@(posedge clk) disable iff (rst)
    (win_valid && no_nest) |-> (insvc == '0)); // R8

  AST_SERVICE_RISE_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    !enter |=> ((insvc & ~$past(insvc)) == '0)); // R6

  AST_ACK_FREES_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ((|ack) && !enter) |=> ((insvc & $past(ack)) == '0)); // R7

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0)); // R11

endmodule

bind irq_collector irq_collector_chk #(.NSRC(NSRC), .NLVL(NLVL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_irq   (cpu_irq),
  .irq_en    (irq_en),
  .no_nest   (no_nest),
  .insvc     (insvc),
  .win_valid (win_valid),
  .win_idx   (win_idx),
  .win_lvl   (win_lvl),
  .req_eff   (req_eff),
  .enter     (enter),
  .ack       (ack),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata)
);

// File: tb/irq_collector_test.sv
`timescale 1ns/1ps
module irq_collector_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_lines = '0;
  logic [8:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        cpu_irq;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] BASE = 32'h8000_1000;

  always #4 clk = ~clk; // 125 MHz

  irq_collector uut (
    .clk       (clk),
    .rst       (rst),
    .irq_lines (irq_lines),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .cpu_irq   (cpu_irq)
  );

  typedef struct packed {
    logic [63:0] lines;
    logic        irq;
    logic [5:0]  idx;
  } vec_t;

  // config used by the table: 5:p1, 9:p1, 12:p0, 20:p3 disabled, 40:p3, 63:p2
  localparam vec_t TBL [10] = '{
    '{64'h0000_0000_0000_0000, 1'b0, 6'd0},
    '{64'h0000_0000_0000_1000, 1'b1, 6'd12},
    '{64'h0000_0000_0000_1020, 1'b1, 6'd5},
    '{64'h0000_0000_0000_0220, 1'b1, 6'd5},
    '{64'h0000_0000_0000_1200, 1'b1, 6'd9},
    '{64'h0000_0000_0010_0000, 1'b0, 6'd0},
    '{64'h0000_0000_0010_1000, 1'b1, 6'd12},
    '{64'h8000_0000_0000_0020, 1'b1, 6'd63},
    '{64'h8000_0100_0000_0020, 1'b1, 6'd40},
    '{64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 6'd40}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_lines(input logic [63:0] v);
    @(posedge clk); #1;
    irq_lines = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    set_lines('1);
    #1 check("R1 irq low after reset", {31'd0, cpu_irq}, 32'd0);
    bus_read(9'h020, d); check("R1 ctrl reset", d, 32'd0);
    bus_read(9'h060, d); check("R1 cfg reset", d, 32'd0);
    bus_read(9'h000, d); check("R1 vector with no winner", d, 32'd0);
    bus_read(9'h1F0, d); check("R1 scratch reset", d, 32'd0);
    set_lines('0);

    // configuration (R3), one word through the set alias (R2)
    bus_write(9'h020, 32'h0001_0000);
    bus_write(9'h160, BASE);
    bus_write(9'h070, 32'h0000_0500);
    bus_write(9'h084, 32'h0000_0500);
    bus_write(9'h090, 32'h0000_0004);
    bus_write(9'h0B0, 32'h0000_0003);
    bus_write(9'h100, 32'h0000_0007);
    bus_write(9'h150, 32'h0600_0000);
    bus_read(9'h080, d); check("R2 set alias on cfg word", d, 32'h0000_0500);

    // R4/R5/R9: arbitration table
    for (int i = 0; i < 10; i++) begin
      set_lines(TBL[i].lines);
      #1 check($sformatf("R9 irq entry %0d", i), {31'd0, cpu_irq}, {31'd0, TBL[i].irq});
      bus_read(9'h030, d);
      check($sformatf("R4 status entry %0d", i), d, TBL[i].irq ? {26'd0, TBL[i].idx} : 32'd0);
      bus_read(9'h000, d);
      check($sformatf("R5 vector entry %0d", i), d,
            TBL[i].irq ? (BASE + {24'd0, TBL[i].idx, 2'b00}) : 32'd0);
    end

    // R10: raw views
    set_lines(64'hA5A5_0000_1234_5678);
    bus_read(9'h040, d); check("R10 raw low", d, 32'h1234_5678);
    bus_read(9'h050, d); check("R10 raw high", d, 32'hA5A5_0000);

    // R2/R9: control aliases gate the output
    set_lines(64'h1000);
    bus_write(9'h028, 32'h0001_0000);
    bus_read(9'h020, d); check("R2 ctrl clear alias", d, 32'd0);
    check("R9 irq off when disabled", {31'd0, cpu_irq}, 32'd0);
    bus_write(9'h02C, 32'h0001_0000);
    bus_read(9'h020, d); check("R2 ctrl toggle alias", d, 32'h0001_0000);
    check("R9 irq back on", {31'd0, cpu_irq}, 32'd1);
    bus_write(9'h020, 32'hFFFF_FFFF);
    bus_read(9'h020, d); check("R2 ctrl keeps only defined bits", d, 32'h000D_0000);
    bus_write(9'h020, 32'h0001_0000);

    // R2/R5: scratch as undefined vector, base low bits
    bus_write(9'h1F0, 32'h0000_1234);
    bus_write(9'h1FC, 32'h0000_00FF);
    bus_read(9'h1F0, d); check("R2 scratch toggle alias", d, 32'h0000_12CB);
    set_lines('0);
    bus_read(9'h000, d); check("R5 vector reads scratch without winner", d, 32'h0000_12CB);
    bus_read(9'h030, d); check("R5 status zero without winner", d, 32'd0);
    bus_write(9'h160, BASE | 32'h3);
    bus_read(9'h160, d); check("R2 base drops low bits", d, BASE);

    // R3: software force and field read-back
    bus_write(9'h094, 32'h0000_0008);
    check("R3 forced source raises irq", {31'd0, cpu_irq}, 32'd1);
    bus_read(9'h030, d); check("R3 forced source wins", d, 32'd12);
    bus_write(9'h098, 32'h0000_00F8);
    check("R3 force cleared", {31'd0, cpu_irq}, 32'd0);
    bus_write(9'h09C, 32'h0000_00F0);
    bus_read(9'h090, d); check("R3 upper nibble reads zero", d, 32'h0000_0004);

    // R6/R7/R8: write entry with nesting on
    set_lines(64'h1000);
    bus_read(9'h000, d);
    check("R6 read does not enter in write mode", {31'd0, cpu_irq}, 32'd1);
    bus_write(9'h000, 32'd0);
    check("R6 write enters level 0", {31'd0, cpu_irq}, 32'd0);
    set_lines(64'h1020);
    #1 check("R8 higher level preempts", {31'd0, cpu_irq}, 32'd1);
    bus_read(9'h030, d); check("R8 preempting source", d, 32'd5);
    bus_write(9'h000, 32'd0);
    check("R8 equal level blocked", {31'd0, cpu_irq}, 32'd0);
    set_lines(64'h0000_0100_0000_1020);
    bus_read(9'h030, d); check("R8 level 3 over level 1", d, 32'd40);
    set_lines(64'h1020);
    #1 check("R8 lower levels blocked", {31'd0, cpu_irq}, 32'd0);
    bus_write(9'h010, 32'h2);
    check("R7 ack frees level 1", {31'd0, cpu_irq}, 32'd1);
    bus_read(9'h030, d); check("R7 level 1 source returns", d, 32'd5);
    bus_write(9'h010, 32'h1);

    // R6: read entry mode
    bus_write(9'h024, 32'h0004_0000);
    set_lines(64'h20);
    bus_write(9'h000, 32'd0);
    check("R6 write ignored in read mode", {31'd0, cpu_irq}, 32'd1);
    bus_read(9'h000, d); check("R6 entry read returns vector", d, BASE + 32'h14);
    check("R6 read enters level 1", {31'd0, cpu_irq}, 32'd0);
    bus_write(9'h010, 32'h2);
    check("R7 ack after read entry", {31'd0, cpu_irq}, 32'd1);

    // R8: nesting off
    bus_write(9'h028, 32'h0004_0000);
    bus_write(9'h024, 32'h0008_0000);
    set_lines(64'h1000);
    bus_write(9'h000, 32'd0);
    set_lines(64'h0000_0100_0000_1000);
    #1 check("R8 no preemption with nesting off", {31'd0, cpu_irq}, 32'd0);
    bus_write(9'h010, 32'h1);
    bus_read(9'h030, d); check("R8 winner after release", d, 32'd40);

    // R11: unmapped address
    bus_read(9'h1A0, d); check("R11 unmapped reads zero", d, 32'd0);
    #1 check("R11 idle data zero", bus_rdata, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule